// File: doc/BRIEF.md
# Logarithmic-Domain Unsigned Adder

This block adds two positive quantities that are each held as a base-2 logarithm. A code holds a sign bit and a non-zero flag. Below them is the logarithm L as a two's-complement fixed-point number with INT_BITS integer bits and FRAC_BITS fraction bits, and the encoded value is 2^L. The block returns the code of the sum. It uses log2(x+y) = Lmax + g(d), where Lmax is the larger logarithm, d is the absolute difference of the two logarithms, and g(d) = log2(1 + 2^-d).

The correction g(d) is not read from a full table indexed by d. The difference is cut into 2^SEG_BITS equal segments over the range 0 <= d < 2^CUT_LOG2. Each segment holds a start value and a slope, both computed at elaboration with GUARD_BITS extra fraction bits. The low bits of d then interpolate linearly inside the segment. This saves table storage at the cost of one small multiplier and one subtractor. When d reaches 2^CUT_LOG2 or more, the correction is treated as zero.

STAGES (1 to 4) sets the number of register cuts. The block accepts one operand pair per cycle and has no stall. It is meant to sit in a fixed-latency arithmetic pipeline, beside logarithmic multipliers and format converters.

Top module: `lns_uadd`

## Requirements
- R1: Word layout, with W = INT_BITS+FRAC_BITS+2: bit W-1 is the sign bit, bit W-2 is the non-zero flag, bits W-3..0 are the logarithm in two's complement with FRAC_BITS fraction bits. A sum of two flagged operands always has the flag set.
- R2: If op_a has its flag clear, the result is op_b bit for bit. Otherwise, if op_b has its flag clear, the result is op_a bit for bit.
- R3: With both flags set and no saturation, the result logarithm is within one fraction LSB of the exact log2(2^La + 2^Lb).
- R4: If |La - Lb| >= 2^CUT_LOG2, the result equals the word of the operand with the larger logarithm, exactly.
- R5: If La equals Lb, the result logarithm is exactly La + 1.0, provided that value is representable.
- R6: If the exact sum logarithm reaches or exceeds the largest code plus one LSB, the result logarithm is the largest positive code, 2^(INT_BITS+FRAC_BITS-1)-1.
- R7: For two flagged operands, the result sign bit is the sign bit of the operand with the larger logarithm; op_a wins a tie.
- R8: For two flagged operands, the result logarithm is never below the larger input logarithm and never above it by more than 1.0.
- R9: Each result appears exactly STAGES rising edges after its operands are sampled, and a new pair may be applied every cycle.
- R10: While rst_n is low, sum_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | INT_BITS+FRAC_BITS+2 | First operand code |
| op_b | input | INT_BITS+FRAC_BITS+2 | Second operand code |
| sum_o | output | INT_BITS+FRAC_BITS+2 | Code of the sum, registered |

## Verification
The bound checker watches several rules on every cycle, comparing the output with the operands seen STAGES cycles earlier. These are the zero-operand pass-through, the exact far-operand result, the flag and sign rules, the lower and upper bounds on the result logarithm, and the zeroed output in reset. Interpolation accuracy can only be shown by the bench. Its sweep covers every pair of logarithms in a small configuration and compares each sum against a real-valued logarithm. The same sweep covers the exact equal-operand result and saturation at the top code. The bench also measures the latency edge by edge with a single isolated pair.

// File: rtl/lns_uadd_pkg.sv
package lns_uadd_pkg;

   // Correction log2(1 + 2^-x) at the start of segment idx, scaled by 2^prec_bits.
   // A segment spans 2^off_bits difference LSBs; one LSB is 2^-frac_bits.
   function automatic int corr_code(input int idx, input int off_bits,
                                    input int frac_bits, input int prec_bits);
      real x;
      real g;
      x = real'(idx) * $pow(2.0, real'(off_bits)) / $pow(2.0, real'(frac_bits));
      g = $ln(1.0 + $pow(2.0, -x)) / $ln(2.0);
      return $rtoi(g * $pow(2.0, real'(prec_bits)) + 0.5);
   endfunction

endpackage

// File: rtl/lns_pipe_cut.sv
module lns_pipe_cut #(
   parameter int WIDTH      = 8,
   parameter bit REGISTERED = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (REGISTERED) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/lns_uadd_prep.sv
module lns_uadd_prep #(
   parameter int INT_BITS  = 7,
   parameter int FRAC_BITS = 8,
   parameter int CUT_LOG2  = 4
)(
   input  logic [INT_BITS+FRAC_BITS+1:0]   a,
   input  logic [INT_BITS+FRAC_BITS+1:0]   b,
   output logic                            byp,
   output logic [INT_BITS+FRAC_BITS+1:0]   byp_word,
   output logic                            sgn,
   output logic [INT_BITS+FRAC_BITS-1:0]   lmax,
   output logic                            far,
   output logic [CUT_LOG2+FRAC_BITS-1:0]   dlow
);
   localparam int LW = INT_BITS + FRAC_BITS;
   localparam int DW = CUT_LOG2 + FRAC_BITS;
   localparam int RW = LW + 1;

   logic [RW-1:0] ea, eb, diff, dmag;
   logic          a_big;

   always_comb begin
      ea    = {a[LW-1], a[LW-1:0]};
      eb    = {b[LW-1], b[LW-1:0]};
      diff  = ea - eb;
      a_big = ~diff[LW];
      dmag  = a_big ? diff : (RW'(0) - diff);
      far   = (dmag >> DW) != '0;
      dlow  = DW'(dmag);
      lmax  = a_big ? a[LW-1:0] : b[LW-1:0];
      sgn   = a_big ? a[LW+1]   : b[LW+1];
      byp      = ~a[LW] | ~b[LW];
      byp_word = ~a[LW] ? b : a;
   end
endmodule

// File: rtl/lns_corr_rom.sv
module lns_corr_rom #(
   parameter int FRAC_BITS = 8,
   parameter int SEG_BITS  = 7,
   parameter int OFF_BITS  = 5,
   parameter int PREC_BITS = 12
)(
   input  logic [SEG_BITS-1:0] addr,
   output logic [PREC_BITS:0]  val,
   output logic [PREC_BITS:0]  slope
);
   localparam int SEGS = 1 << SEG_BITS;
   localparam int VW   = PREC_BITS + 1;

   logic [VW-1:0] val_tab [SEGS];
   logic [VW-1:0] slp_tab [SEGS];

   generate
      for (genvar g = 0; g < SEGS; g++) begin : g_seg
         localparam int V0 = lns_uadd_pkg::corr_code(g,     OFF_BITS, FRAC_BITS, PREC_BITS);
         localparam int V1 = lns_uadd_pkg::corr_code(g + 1, OFF_BITS, FRAC_BITS, PREC_BITS);
         assign val_tab[g] = VW'(V0);
         assign slp_tab[g] = VW'(V0 - V1);
      end
   endgenerate

   assign val   = val_tab[addr];
   assign slope = slp_tab[addr];
endmodule

// File: rtl/lns_interp.sv
module lns_interp #(
   parameter int VAL_BITS = 13,
   parameter int OFF_BITS = 5
)(
   input  logic [VAL_BITS-1:0] val,
   input  logic [VAL_BITS-1:0] slope,
   input  logic [OFF_BITS-1:0] off,
   output logic [VAL_BITS-1:0] corr
);
   localparam int PW = VAL_BITS + OFF_BITS;

   logic [PW-1:0] prod;

   always_comb begin
      prod = PW'(slope) * PW'(off);
      corr = val - VAL_BITS'(prod >> OFF_BITS);
   end
endmodule

// File: rtl/lns_uadd.sv
module lns_uadd #(
   parameter int INT_BITS   = 7,
   parameter int FRAC_BITS  = 8,
   parameter int SEG_BITS   = 7,
   parameter int CUT_LOG2   = 4,
   parameter int GUARD_BITS = 4,
   parameter int STAGES     = 4
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [INT_BITS+FRAC_BITS+1:0] op_a,
   input  logic [INT_BITS+FRAC_BITS+1:0] op_b,
   output logic [INT_BITS+FRAC_BITS+1:0] sum_o
);
   localparam int LW   = INT_BITS + FRAC_BITS;
   localparam int W    = LW + 2;
   localparam int DW   = CUT_LOG2 + FRAC_BITS;
   localparam int OFF  = DW - SEG_BITS;
   localparam int P    = FRAC_BITS + GUARD_BITS;
   localparam int VW   = P + 1;
   localparam int RW   = LW + 1;
   localparam int SW   = LW + 1 + GUARD_BITS;
   localparam int HDR  = 1 + W + 1 + LW + 1;
   localparam int C0W  = HDR + DW;
   localparam int C1W  = HDR + VW + VW + OFF;
   localparam int C2W  = HDR + VW;
   localparam int SEGS = 1 << SEG_BITS;

   // elaboration-time parameter checks
   generate
      if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
         $error("lns_uadd: STAGES must be 1..4");
      end
      if (SEG_BITS < 1 || SEG_BITS >= DW) begin : g_bad_seg
         $error("lns_uadd: SEG_BITS must leave at least one offset bit");
      end
      if (CUT_LOG2 < 1 || CUT_LOG2 > INT_BITS) begin : g_bad_cut
         $error("lns_uadd: CUT_LOG2 must be 1..INT_BITS");
      end
      if (GUARD_BITS < 1) begin : g_bad_guard
         $error("lns_uadd: GUARD_BITS must be at least 1");
      end
      if (lns_uadd_pkg::corr_code(SEGS, OFF, FRAC_BITS, P) >= (1 << (GUARD_BITS - 1))) begin : g_bad_tail
         $error("lns_uadd: correction at the cutoff does not round to zero");
      end
   endgenerate

   // ---------------- stage A: operand compare and difference
   logic          p_byp, p_sgn, p_far;
   logic [W-1:0]  p_bw;
   logic [LW-1:0] p_lmax;
   logic [DW-1:0] p_dlow;

   lns_uadd_prep #(
      .INT_BITS (INT_BITS),
      .FRAC_BITS(FRAC_BITS),
      .CUT_LOG2 (CUT_LOG2)
   ) u_prep (
      .a       (op_a),
      .b       (op_b),
      .byp     (p_byp),
      .byp_word(p_bw),
      .sgn     (p_sgn),
      .lmax    (p_lmax),
      .far     (p_far),
      .dlow    (p_dlow)
   );

   logic [C0W-1:0] c0_q;
   logic           s0_byp, s0_sgn, s0_far;
   logic [W-1:0]   s0_bw;
   logic [LW-1:0]  s0_lmax;
   logic [DW-1:0]  s0_dlow;

   lns_pipe_cut #(.WIDTH(C0W), .REGISTERED(STAGES >= 4)) u_cut0 (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({p_byp, p_bw, p_sgn, p_lmax, p_far, p_dlow}),
      .q    (c0_q)
   );
   assign {s0_byp, s0_bw, s0_sgn, s0_lmax, s0_far, s0_dlow} = c0_q;

   // ---------------- stage B: segment table read
   logic [SEG_BITS-1:0] r_addr;
   logic [OFF-1:0]      r_off;
   logic [VW-1:0]       r_val, r_slp;

   assign r_addr = SEG_BITS'(s0_dlow >> OFF);
   assign r_off  = OFF'(s0_dlow);

   lns_corr_rom #(
      .FRAC_BITS(FRAC_BITS),
      .SEG_BITS (SEG_BITS),
      .OFF_BITS (OFF),
      .PREC_BITS(P)
   ) u_rom (
      .addr (r_addr),
      .val  (r_val),
      .slope(r_slp)
   );

   logic [C1W-1:0] c1_q;
   logic           s1_byp, s1_sgn, s1_far;
   logic [W-1:0]   s1_bw;
   logic [LW-1:0]  s1_lmax;
   logic [VW-1:0]  s1_val, s1_slp;
   logic [OFF-1:0] s1_off;

   lns_pipe_cut #(.WIDTH(C1W), .REGISTERED(STAGES >= 3)) u_cut1 (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({s0_byp, s0_bw, s0_sgn, s0_lmax, s0_far, r_val, r_slp, r_off}),
      .q    (c1_q)
   );
   assign {s1_byp, s1_bw, s1_sgn, s1_lmax, s1_far, s1_val, s1_slp, s1_off} = c1_q;

   // ---------------- stage C: linear interpolation
   logic [VW-1:0] i_corr;

   lns_interp #(.VAL_BITS(VW), .OFF_BITS(OFF)) u_interp (
      .val  (s1_val),
      .slope(s1_slp),
      .off  (s1_off),
      .corr (i_corr)
   );

   logic [C2W-1:0] c2_q;
   logic           s2_byp, s2_sgn, s2_far;
   logic [W-1:0]   s2_bw;
   logic [LW-1:0]  s2_lmax;
   logic [VW-1:0]  s2_corr;

   lns_pipe_cut #(.WIDTH(C2W), .REGISTERED(STAGES >= 2)) u_cut2 (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({s1_byp, s1_bw, s1_sgn, s1_lmax, s1_far, i_corr}),
      .q    (c2_q)
   );
   assign {s2_byp, s2_bw, s2_sgn, s2_lmax, s2_far, s2_corr} = c2_q;

   // ---------------- stage D: add, round, saturate, select
   logic [SW-1:0] sum_fx;
   logic [RW-1:0] res;
   logic          ovf;
   logic [LW-1:0] res_l;
   logic [W-1:0]  f_word;

   always_comb begin
      sum_fx = {s2_lmax[LW-1], s2_lmax, {GUARD_BITS{1'b0}}}
             + (s2_far ? SW'(0) : SW'(s2_corr))
             + (SW'(1) << (GUARD_BITS - 1));
      res    = RW'(sum_fx >> GUARD_BITS);
      ovf    = res[LW] ^ res[LW-1];
      res_l  = ovf ? {1'b0, {(LW-1){1'b1}}} : res[LW-1:0];
      f_word = s2_byp ? s2_bw : {s2_sgn, 1'b1, res_l};
   end

   lns_pipe_cut #(.WIDTH(W), .REGISTERED(1'b1)) u_cut3 (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (f_word),
      .q    (sum_o)
   );
endmodule

// File: rtl/lns_uadd_chk.sv
module lns_uadd_chk #(
   parameter int INT_BITS   = 7,
   parameter int FRAC_BITS  = 8,
   parameter int SEG_BITS   = 7,
   parameter int CUT_LOG2   = 4,
   parameter int GUARD_BITS = 4,
   parameter int STAGES     = 4
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic [INT_BITS+FRAC_BITS+1:0] op_a,
   input logic [INT_BITS+FRAC_BITS+1:0] op_b,
   input logic [INT_BITS+FRAC_BITS+1:0] sum_o
);
   localparam int LW    = INT_BITS + FRAC_BITS;
   localparam int W     = LW + 2;
   localparam int FAR_D = 1 << (CUT_LOG2 + FRAC_BITS);
   localparam int ONE   = 1 << FRAC_BITS;
   localparam int SEGW  = SEG_BITS + GUARD_BITS;

   logic [2:0] seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen <= '0;
      else if (seen != 3'(STAGES))   seen <= seen + 3'd1;
   end
   wire ready = (seen == 3'(STAGES)) && (SEGW > 0);

   int           la_i, lb_i, big_i, out_i;
   logic         both_nz, far_now, big_sgn;
   logic [W-1:0] big_word;

   always_comb begin
      la_i     = int'($signed(op_a[LW-1:0]));
      lb_i     = int'($signed(op_b[LW-1:0]));
      out_i    = int'($signed(sum_o[LW-1:0]));
      both_nz  = op_a[LW] & op_b[LW];
      big_i    = (la_i >= lb_i) ? la_i : lb_i;
      big_word = (la_i >= lb_i) ? op_a : op_b;
      big_sgn  = big_word[LW+1];
      far_now  = ((la_i - lb_i) >= FAR_D) || ((lb_i - la_i) >= FAR_D);
   end

   // R10
   a_r10_reset_zero: assert property (@(posedge clk)
      !rst_n |=> sum_o == '0);

   // R2
   a_r2_a_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      ready && !$past(op_a[LW], STAGES) |-> sum_o == $past(op_b, STAGES));

   a_r2_b_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(op_a[LW], STAGES) && !$past(op_b[LW], STAGES)
      |-> sum_o == $past(op_a, STAGES));

   // R4
   a_r4_far_larger: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(both_nz && far_now, STAGES) |-> sum_o == $past(big_word, STAGES));

   // R1 and R7
   a_r7_flag_sign: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(both_nz, STAGES)
      |-> sum_o[LW] && (sum_o[LW+1] == $past(big_sgn, STAGES)));

   // R8
   a_r8_not_below: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(both_nz, STAGES) |-> out_i >= $past(big_i, STAGES));

   a_r8_not_above: assert property (@(posedge clk) disable iff (!rst_n)
      ready && $past(both_nz, STAGES) |-> out_i <= $past(big_i, STAGES) + ONE);
endmodule

bind lns_uadd lns_uadd_chk #(
   .INT_BITS  (INT_BITS),
   .FRAC_BITS (FRAC_BITS),
   .SEG_BITS  (SEG_BITS),
   .CUT_LOG2  (CUT_LOG2),
   .GUARD_BITS(GUARD_BITS),
   .STAGES    (STAGES)
) chk_i (
   .clk  (clk),
   .rst_n(rst_n),
   .op_a (op_a),
   .op_b (op_b),
   .sum_o(sum_o)
);

// File: tb/lns_uadd_tb_top.sv
module lns_uadd_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int M   = 4;
   localparam int N   = 4;
   localparam int LAT = 4;
   localparam int W   = M + N + 2;
   localparam int LW  = M + N;
   localparam int MAXC = (1 << (LW - 1)) - 1;
   localparam int FARD = 1 << (3 + N);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] sum_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [W-1:0] ha [LAT];
   logic [W-1:0] hb [LAT];
   bit           hv [LAT];

   always #(CLK_PERIOD / 2) clk = ~clk;

   lns_uadd #(
      .INT_BITS(M), .FRAC_BITS(N), .SEG_BITS(4),
      .CUT_LOG2(3), .GUARD_BITS(3), .STAGES(LAT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sum_o(sum_o)
   );

   task automatic report(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic check_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [W-1:0] got);
      int la, lb, lm, d, gl;
      bit sg;
      logic [W-1:0] bw;
      real ex;
      if (!a[LW]) begin
         report(got == b, "R2 a-zero", int'(got), int'(b));
      end else if (!b[LW]) begin
         report(got == a, "R2 b-zero", int'(got), int'(a));
      end else begin
         la = int'($signed(a[LW-1:0]));
         lb = int'($signed(b[LW-1:0]));
         gl = int'($signed(got[LW-1:0]));
         lm = (la >= lb) ? la : lb;
         bw = (la >= lb) ? a : b;
         sg = bw[LW+1];
         d  = (la >= lb) ? la - lb : lb - la;
         report(got[LW] == 1'b1, "R1 flag", int'(got[LW]), 1);
         report(got[LW+1] == sg, "R7 sign", int'(got[LW+1]), int'(sg));
         if (d >= FARD) begin
            report(got == bw, "R4 far", int'(got), int'(bw));
         end else begin
            ex = real'(lm) + real'(1 << N) *
                 ($ln(1.0 + $pow(2.0, -real'(d) / real'(1 << N))) / $ln(2.0));
            if (ex >= real'(MAXC + 1)) begin
               report(gl == MAXC, "R6 saturate", gl, MAXC);
            end else if (d == 0) begin
               report(gl == lm + (1 << N), "R5 equal", gl, lm + (1 << N));
            end else begin
               report((real'(gl) - ex) < 1.0 && (ex - real'(gl)) < 1.0,
                      "R3 accuracy", gl, $rtoi(ex + 0.5));
               report(gl >= lm && gl <= lm + (1 << N), "R8 bounds", gl, lm);
            end
         end
      end
   endtask

   // R9: each pair is checked exactly LAT negedges after it was applied
   task automatic feed(input logic [W-1:0] a, input logic [W-1:0] b, input bit v);
      @(negedge clk);
      if (hv[LAT-1]) check_pair(ha[LAT-1], hb[LAT-1], sum_o);
      for (int k = LAT - 1; k > 0; k--) begin
         ha[k] = ha[k-1];
         hb[k] = hb[k-1];
         hv[k] = hv[k-1];
      end
      ha[0] = a;
      hb[0] = b;
      hv[0] = v;
      op_a  = a;
      op_b  = b;
   endtask

   task automatic flush();
      for (int k = 0; k < LAT; k++) feed('0, '0, 1'b0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      for (int k = 0; k < LAT; k++) begin
         ha[k] = '0;
         hb[k] = '0;
         hv[k] = 1'b0;
      end
      // R10: reset with busy operands
      op_a = {2'b01, 8'h35};
      op_b = {2'b11, 8'h12};
      repeat (3) begin
         @(negedge clk);
         report(sum_o == '0, "R10 reset", int'(sum_o), 0);
      end
      rst_n = 1'b1;
      flush();

      // R9: isolated pair, output changes only after LAT edges
      op_a = '0;
      op_b = '0;
      repeat (LAT + 1) @(negedge clk);
      op_a = {2'b01, 8'h00};
      op_b = {2'b01, 8'h00};
      @(negedge clk);
      op_a = '0;
      op_b = '0;
      for (int k = 1; k < LAT; k++) begin
         report(sum_o == '0, "R9 early", int'(sum_o), 0);
         @(negedge clk);
      end
      report(sum_o == {2'b01, 8'h10}, "R9 on time", int'(sum_o), int'({2'b01, 8'h10}));

      // exhaustive sweep over both logarithms, mixed sign bits
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            feed({i[0], 1'b1, 8'(i)}, {j[3], 1'b1, 8'(j)}, 1'b1);
         end
      end
      flush();

      // R2: zero-flagged operands with arbitrary other bits
      for (int i = 0; i < 256; i++) begin
         feed({1'b1, 1'b0, 8'(i)}, {i[1], 1'b1, 8'(255 - i)}, 1'b1);
         feed({i[2], 1'b1, 8'(i)}, {1'b0, 1'b0, 8'(i * 7)}, 1'b1);
         feed({i[0], 1'b0, 8'(i)}, {i[1], 1'b0, 8'(i + 3)}, 1'b1);
      end
      flush();

      // R10: reset again mid-stream
      feed({2'b01, 8'h40}, {2'b01, 8'h41}, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      report(sum_o == '0, "R10 mid reset", int'(sum_o), 0);
      rst_n = 1'b1;

      summary();
      finished = 1'b1;
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         report(1'b0, "R9 watchdog", 0, 1);
         summary();
         $finish;
      end
   end
endmodule